// File: doc/BRIEF.md
# Nibble-Serial 8-Bit ALU with Condition Flags

This block does 8-bit arithmetic and logic on a datapath that is only one nibble wide. A start strobe captures both operands, the operation code and the incoming carry flag. The 4-bit core then handles the low nibble. Its result, its carry out and its zero and parity indications are latched. In the following cycle the same core handles the high nibble, with the latched carry as its carry-in. The two halves are then joined into the 8-bit result, and a condition flag byte is produced at the same time.

The host pulses `start` while the unit is idle. Two clocks later `done` rises for a single cycle, and `result` and `flags` are valid from then on. They hold until the next operation finishes. Compare runs the subtraction only to update the flags, so the result register keeps its earlier value.

Top module: `nib_alu`

## Requirements
- R1: While reset is held, and after it is released, `result` and `flags` read zero and `done` reads 0.
- R2: A `start` sampled high at a rising edge while idle gives a one-cycle `done` pulse two edges later. `start` is ignored while an operation is in progress, including any operand or code change made in that time.
- R3: Codes 0 (add) and 1 (add with carry) give result = A + B + cin, where cin is 0 for code 0 and `carry_in` for code 1. Flag bit 0 is the carry out of bit 7.
- R4: Codes 2 (subtract) and 3 (subtract with borrow) give result = A - B - bin, where bin is 0 for code 2 and `carry_in` for code 3. Flag bit 0 is 1 when the subtraction borrowed.
- R5: For the arithmetic codes (0, 1, 2, 3, 7), flag bit 4 is the carry out of bit 3 for addition and the borrow out of bit 3 for subtraction.
- R6: For the arithmetic codes, flag bit 2 is two's-complement overflow: the carry into bit 7 XOR the carry out of bit 7 of the internal sum.
- R7: Codes 4 (AND), 5 (OR) and 6 (XOR) give the bitwise result and clear flag bit 0. Flag bit 4 is 1 for AND and 0 for OR and XOR.
- R8: For the logic codes, flag bit 2 is 1 when the 8-bit result has an even number of one bits.
- R9: Flag bit 6 is 1 exactly when the 8-bit value computed is zero. Flag bit 7 is bit 7 of that value. For compare, this value is the difference.
- R10: Code 7 (compare) sets the flags exactly as subtraction of the same operands would, and leaves `result` unchanged.
- R11: Flag bits 1, 3 and 5 are always 0. `flags` and `result` change only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| op | input | 3 | Operation code, 0..7 as listed in the requirements |
| opa | input | 8 | First operand A |
| opb | input | 8 | Second operand B |
| carry_in | input | 1 | Current carry flag, used by codes 1 and 3 |
| result | output | 8 | Last 8-bit result |
| flags | output | 8 | Condition flag byte: C bit 0, P/V bit 2, H bit 4, Z bit 6, S bit 7 |
| done | output | 1 | One-cycle pulse when result and flags are updated |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that every 3-bit code is legal, and that nothing outside the block writes the result or flag registers between operations. The bench always holds reset for several edges. It changes inputs only at falling edges, and it draws operation codes from the whole 0..7 range. It keeps `start` low except when it launches an operation, apart from deliberate cases where it holds `start` high and changes the operands during a busy cycle. This checks that such activity is ignored.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBC = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_CMP = 3'd7
   } alu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2
   } seq_state_e;

   localparam int FLAG_W    = 8;
   localparam int FLAG_C    = 0;
   localparam int FLAG_PV   = 2;
   localparam int FLAG_H    = 4;
   localparam int FLAG_Z    = 6;
   localparam int FLAG_S    = 7;

   function automatic logic op_is_sub(alu_op_e o);
      return (o == OP_SUB) || (o == OP_SBC) || (o == OP_CMP);
   endfunction

   function automatic logic op_is_logic(alu_op_e o);
      return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
   endfunction

endpackage

// File: rtl/nib_alu_core.sv
module nib_alu_core
   import nib_alu_pkg::*;
#(
   parameter int NIB_W       = 4,
   parameter int CARRY_STYLE = 0
) (
   input  alu_op_e          op,
   input  logic [NIB_W-1:0] a,
   input  logic [NIB_W-1:0] b,
   input  logic             cin,
   output logic [NIB_W-1:0] res,
   output logic             cout,
   output logic             c_msb_in
);

   logic [NIB_W-1:0] b_eff;
   logic [NIB_W-1:0] sum;

   assign b_eff = op_is_sub(op) ? ~b : b;

   generate
      if (CARRY_STYLE == 0) begin : g_ripple
         logic [NIB_W:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < NIB_W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1]  = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
         end
         assign cout     = cy[NIB_W];
         assign c_msb_in = cy[NIB_W-1];
      end else begin : g_behav
         logic [NIB_W:0]   full;
         logic [NIB_W-1:0] part;
         assign full     = {1'b0, a} + {1'b0, b_eff} + {{NIB_W{1'b0}}, cin};
         assign part     = {1'b0, a[NIB_W-2:0]} + {1'b0, b_eff[NIB_W-2:0]}
                           + {{(NIB_W-1){1'b0}}, cin};
         assign sum      = full[NIB_W-1:0];
         assign cout     = full[NIB_W];
         assign c_msb_in = part[NIB_W-1];
      end
   endgenerate

   always_comb begin
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = sum;
      endcase
   end

endmodule

// File: rtl/nib_alu_detect.sv
module nib_alu_detect #(
   parameter int NIB_W = 4
) (
   input  logic [NIB_W-1:0] val,
   output logic             is_zero,
   output logic             odd_ones
);

   assign is_zero  = (val == '0);
   assign odd_ones = ^val;

endmodule

// File: rtl/nib_alu_seq.sv
module nib_alu_seq
   import nib_alu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic in_lo,
   output logic in_hi
);

   seq_state_e state_q;

   assign accept = (state_q == ST_IDLE) && start;
   assign in_lo  = (state_q == ST_LO);
   assign in_hi  = (state_q == ST_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (start) state_q <= ST_LO;
            ST_LO:   state_q <= ST_HI;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_lo_then_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_lo |=> in_hi);

   p_hi_then_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_hi |=> (!in_lo && !in_hi));

   p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({accept, in_lo, in_hi}));

endmodule

// File: rtl/nib_alu.sv
module nib_alu
   import nib_alu_pkg::*;
#(
   parameter int NIB_W       = 4,
   parameter int CARRY_STYLE = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [2:0]           op,
   input  logic [2*NIB_W-1:0]   opa,
   input  logic [2*NIB_W-1:0]   opb,
   input  logic                 carry_in,
   output logic [2*NIB_W-1:0]   result,
   output logic [FLAG_W-1:0]    flags,
   output logic                 done
);

   localparam int DATA_W = 2 * NIB_W;

   generate
      if (NIB_W < 2) begin : g_bad_width
         $error("nib_alu: NIB_W must be at least 2");
      end
      if (CARRY_STYLE != 0 && CARRY_STYLE != 1) begin : g_bad_style
         $error("nib_alu: CARRY_STYLE must be 0 or 1");
      end
   endgenerate

   logic accept, in_lo, in_hi;

   nib_alu_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .accept (accept),
      .in_lo  (in_lo),
      .in_hi  (in_hi)
   );

   logic [DATA_W-1:0] opa_q, opb_q;
   alu_op_e           op_q;
   logic              c0_q;
   alu_op_e           op_in;

   assign op_in = alu_op_e'(op);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opa_q <= '0;
         opb_q <= '0;
         op_q  <= OP_ADD;
         c0_q  <= 1'b0;
      end else if (accept) begin
         opa_q <= opa;
         opb_q <= opb;
         op_q  <= op_in;
         case (op_in)
            OP_ADC:         c0_q <= carry_in;
            OP_SUB, OP_CMP: c0_q <= 1'b1;
            OP_SBC:         c0_q <= ~carry_in;
            default:        c0_q <= 1'b0;
         endcase
      end
   end

   logic [NIB_W-1:0] nib_a, nib_b, nib_r;
   logic             nib_cin, nib_cout, nib_cmsb;
   logic             lo_cout_q;

   assign nib_a   = in_hi ? opa_q[DATA_W-1:NIB_W] : opa_q[NIB_W-1:0];
   assign nib_b   = in_hi ? opb_q[DATA_W-1:NIB_W] : opb_q[NIB_W-1:0];
   assign nib_cin = in_hi ? lo_cout_q : c0_q;

   nib_alu_core #(.NIB_W(NIB_W), .CARRY_STYLE(CARRY_STYLE)) u_core (
      .op       (op_q),
      .a        (nib_a),
      .b        (nib_b),
      .cin      (nib_cin),
      .res      (nib_r),
      .cout     (nib_cout),
      .c_msb_in (nib_cmsb)
   );

   logic nib_zero, nib_odd;

   nib_alu_detect #(.NIB_W(NIB_W)) u_detect (
      .val      (nib_r),
      .is_zero  (nib_zero),
      .odd_ones (nib_odd)
   );

   logic [NIB_W-1:0] lo_res_q;
   logic             lo_zero_q, lo_odd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_res_q  <= '0;
         lo_cout_q <= 1'b0;
         lo_zero_q <= 1'b0;
         lo_odd_q  <= 1'b0;
      end else if (in_lo) begin
         lo_res_q  <= nib_r;
         lo_cout_q <= nib_cout;
         lo_zero_q <= nib_zero;
         lo_odd_q  <= nib_odd;
      end
   end

   logic [FLAG_W-1:0] flags_d;

   always_comb begin
      flags_d         = '0;
      flags_d[FLAG_Z] = lo_zero_q & nib_zero;
      flags_d[FLAG_S] = nib_r[NIB_W-1];
      if (op_is_logic(op_q)) begin
         flags_d[FLAG_C]  = 1'b0;
         flags_d[FLAG_H]  = (op_q == OP_AND);
         flags_d[FLAG_PV] = ~(lo_odd_q ^ nib_odd);
      end else begin
         flags_d[FLAG_C]  = op_is_sub(op_q) ? ~nib_cout  : nib_cout;
         flags_d[FLAG_H]  = op_is_sub(op_q) ? ~lo_cout_q : lo_cout_q;
         flags_d[FLAG_PV] = nib_cmsb ^ nib_cout;
      end
   end

   logic [DATA_W-1:0] result_q;
   logic [FLAG_W-1:0] flags_q;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         flags_q  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= in_hi;
         if (in_hi) begin
            flags_q <= flags_d;
            if (op_q != OP_CMP) result_q <= {nib_r, lo_res_q};
         end
      end
   end

   assign result = result_q;
   assign flags  = flags_q;
   assign done   = done_q;

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_logic_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_is_logic(op_q)) |-> !flags[FLAG_C]);

   p_zero_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q != OP_CMP) |-> (flags[FLAG_Z] == (result == '0)));

   p_sign_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q != OP_CMP) |-> (flags[FLAG_S] == result[DATA_W-1]));

   p_cmp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_CMP) |-> (result == $past(result)));

   p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(flags) && $stable(result)));

   p_spare_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!flags[1] && !flags[3] && !flags[5]));

endmodule

// File: tb/nib_alu_bench.sv
module nib_alu_bench;

   localparam logic [2:0] C_ADD = 3'd0, C_ADC = 3'd1, C_SUB = 3'd2, C_SBC = 3'd3,
                          C_AND = 3'd4, C_OR  = 3'd5, C_XOR = 3'd6, C_CMP = 3'd7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] op = 3'd0;
   logic [7:0] opa = 8'd0, opb = 8'd0;
   logic       carry_in = 1'b0;
   logic [7:0] result, flags;
   logic       done;

   int total = 0;
   int bad   = 0;
   logic [7:0] exp_res = 8'd0;

   always #2.5 clk = ~clk;

   nib_alu u_nib_alu (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
      .carry_in(carry_in), .result(result), .flags(flags), .done(done)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   function automatic string main_req(input logic [2:0] o);
      if (o == C_ADD || o == C_ADC) return "R3";
      if (o == C_SUB || o == C_SBC) return "R4";
      if (o == C_CMP) return "R10";
      return "R7";
   endfunction

   // returns {value, flags}; value is the 8-bit arithmetic/logic value
   function automatic logic [15:0] model(input logic [2:0] o, input logic [7:0] a,
                                         input logic [7:0] b, input logic ci);
      logic [7:0] v, f, bx;
      logic       c0, sub, c8, c7, c4;
      logic [8:0] s9;
      logic [7:0] s7;
      logic [4:0] s4;
      f = 8'd0;
      if (o == C_AND || o == C_OR || o == C_XOR) begin
         v = (o == C_AND) ? (a & b) : (o == C_OR) ? (a | b) : (a ^ b);
         f[4] = (o == C_AND);
         f[2] = ~(^v);
      end else begin
         sub = (o == C_SUB || o == C_SBC || o == C_CMP);
         bx  = sub ? ~b : b;
         c0  = (o == C_ADD) ? 1'b0 : (o == C_ADC) ? ci : (o == C_SBC) ? ~ci : 1'b1;
         s9  = {1'b0, a} + {1'b0, bx} + {8'd0, c0};
         s7  = {1'b0, a[6:0]} + {1'b0, bx[6:0]} + {7'd0, c0};
         s4  = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'd0, c0};
         v   = s9[7:0];
         c8  = s9[8]; c7 = s7[7]; c4 = s4[4];
         f[0] = sub ? ~c8 : c8;
         f[4] = sub ? ~c4 : c4;
         f[2] = c7 ^ c8;
      end
      f[6] = (v == 8'd0);
      f[7] = v[7];
      return {v, f};
   endfunction

   task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic ci, input bit hold_start);
      logic [15:0] m;
      string rq, hr, pr;
      m = model(o, a, b, ci);
      @(negedge clk);
      op = o; opa = a; opb = b; carry_in = ci; start = 1'b1;
      @(negedge clk);
      if (hold_start) begin
         opa = ~a; opb = b ^ 8'h5A; op = o ^ 3'd1; carry_in = ~ci;
      end else begin
         start = 1'b0;
      end
      chk("R2", "done early (1)", {7'd0, done}, 8'd0);
      @(negedge clk);
      start = 1'b0;
      chk("R2", "done early (2)", {7'd0, done}, 8'd0);
      @(negedge clk);
      chk("R2", "done pulse", {7'd0, done}, 8'd1);
      if (o != C_CMP) exp_res = m[15:8];
      rq = main_req(o);
      chk(rq, "result", result, exp_res);
      hr = (o >= C_AND && o <= C_XOR) ? "R7" : "R5";
      pr = (o >= C_AND && o <= C_XOR) ? "R8" : "R6";
      chk(rq, "flag C", {7'd0, flags[0]}, {7'd0, m[0]});
      chk(hr, "flag H", {7'd0, flags[4]}, {7'd0, m[4]});
      chk(pr, "flag P/V", {7'd0, flags[2]}, {7'd0, m[2]});
      chk("R9", "flags Z,S", {6'd0, flags[7:6]}, {6'd0, m[7:6]});
      chk("R11", "spare flag bits", {5'd0, flags[5], flags[3], flags[1]}, 8'd0);
      @(negedge clk);
      chk("R2", "done single cycle", {7'd0, done}, 8'd0);
      chk("R11", "result held", result, exp_res);
      chk("R11", "flags held", flags, m[7:0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240917));
      repeat (4) @(negedge clk);
      chk("R1", "result in reset", result, 8'd0);
      chk("R1", "flags in reset", flags, 8'd0);
      chk("R1", "done in reset", {7'd0, done}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "result after reset", result, 8'd0);
      chk("R1", "flags after reset", flags, 8'd0);
      chk("R1", "done after reset", {7'd0, done}, 8'd0);

      // directed corners
      run_op(C_ADD, 8'h0F, 8'h01, 1'b1, 0);  // R5 half carry, cin ignored for plain add
      run_op(C_ADD, 8'h7F, 8'h01, 1'b0, 0);  // R6 overflow
      run_op(C_ADD, 8'hFF, 8'h01, 1'b0, 0);  // R3 carry, R9 zero
      run_op(C_ADC, 8'hFF, 8'h00, 1'b1, 0);  // R3 carry-in used
      run_op(C_SUB, 8'h00, 8'h01, 1'b0, 0);  // R4 borrow, R5 half borrow
      run_op(C_SUB, 8'h80, 8'h01, 1'b1, 0);  // R6 overflow on subtract
      run_op(C_SBC, 8'h10, 8'h0F, 1'b1, 0);  // R4 borrow-in, R9 zero
      run_op(C_AND, 8'hF0, 8'h0F, 1'b1, 0);  // R7 H=1, R8 even parity
      run_op(C_OR,  8'h01, 8'h02, 1'b1, 0);  // R8 even
      run_op(C_XOR, 8'h01, 8'h00, 1'b1, 0);  // R8 odd
      run_op(C_CMP, 8'h42, 8'h42, 1'b0, 0);  // R10 result kept
      run_op(C_CMP, 8'h10, 8'h20, 1'b0, 1);  // R10 with R2 busy start
      run_op(C_ADD, 8'h33, 8'h44, 1'b0, 1);  // R2 busy start ignored

      for (int i = 0; i < 400; i++) begin
         run_op(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom),
                1'($urandom), ($urandom_range(0, 7) == 0));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule